// File: doc/BRIEF.md
# Modem Link Supervisor

This block runs the polling loop between a serial USART and a host. Each poll pass does four steps in a fixed order. It clears the return code. It forwards one outbound byte if the link allows it. It takes one inbound byte if the modem is present. It then handles the keyboard, the BREAK input and the time base. On transmit, the byte 0x23 is rewritten to 0x5F. On receive, a byte with a parity error is replaced by the marker 0xFF, and the stored command word is written back to the USART to clear its error flags.

Two watchdogs guard the session.

- **Idle counter.** It reloads whenever the modem reports Data Set Ready during a receive step.
- **Carrier counter.** It reloads whenever a byte is accepted. Its reload value depends on the mode: the online value, or the offline value when auto-answer is on, or a default. One is added to the high byte of the chosen value.

Both counters count scan ticks. When either one expires, the session ends with a return code. A BREAK input ends the session at once. The code stays visible in the done state until `go_i` starts a new session.

The state machine has six states:

- `ST_IDLE` is the state after reset.
- `ST_CLEAR`, `ST_TX`, `ST_RX` and `ST_KEY` are the four steps of one poll pass.
- `ST_DONE` holds a stopped session.

The transitions are:

- `ST_IDLE` or `ST_DONE` goes to `ST_CLEAR` on `go_i` (start).
- `ST_CLEAR` goes to `ST_TX`, then to `ST_RX`, then to `ST_KEY` (advance).
- `ST_KEY` goes back to `ST_CLEAR` when the return code is 0 (continue).
- `ST_KEY` goes to `ST_DONE` when the return code is nonzero (stop).

Top module: `modem_link_supervisor`

## Requirements
- R1: A byte is written to the USART (`tx_wr_o`) only in a pass where `link_en_i`, `txrdy_i` and `txq_valid_i` are all high. When that happens, the transmit queue is popped in the same cycle.
- R2: An outbound byte 0x23 appears on `tx_data_o` as 0x5F. Every other byte passes through unchanged.
- R3: No receive read (`rx_rd_o`) takes place while `tx_busy_i` is high or `dsr_i` is low.
- R4: In a receive step with `dsr_i` high and `tx_busy_i` low, the idle counter reloads to IDLE_RELOAD ticks, whether or not a byte is waiting.
- R5: A received byte with `perr_i` high is queued as 0xFF, and `cmd_wr_o` pulses with `cmd_data_o` = CMD_VALUE.
- R6: Each accepted received byte is pushed to the receive queue (`rxq_push_o`) and reloads the carrier counter.
- R7: The carrier reload value is chosen as follows.
  - When `online_i` is high, it is `online_tmo_i`.
  - Otherwise, when `autoans_i` is high, it is `offline_tmo_i`.
  - Otherwise, it is CARRIER_DEFAULT.
  
  In every case, 1 is added to the high byte, which gives value + 256 ticks. The counter is also loaded at session start.
- R8: Each scan tick decrements both counters once. When the idle counter reaches zero, the session ends with code 2.
- R9: When the carrier counter reaches zero, the session ends with code 3.
- R10: `break_i` high in a keyboard step ends the session with code 1.
- R11: When BREAK and a timeout fall in the same keyboard step, the lower code wins: 1 over 2 over 3.
- R12: After reset, `code_o` = 0 and neither `running_o` nor `done_o` is set. While a session runs, `code_o` is 0, and `go_i` starts a new session with the code cleared. A stopped session holds its code.
- R13: A key byte (`key_valid_i`) is acknowledged in the keyboard step. It is forwarded on `key_out_valid_o` only when `kblock_i` is low, and is discarded otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go_i | input | 1 | Start a session from idle or done |
| break_i | input | 1 | BREAK request |
| scan_tick_i | input | 1 | Time-base pulse for both watchdogs |
| online_i | input | 1 | Link is online |
| autoans_i | input | 1 | Auto-answer mode |
| kblock_i | input | 1 | Keyboard lock: discard key bytes |
| tx_busy_i | input | 1 | Transmit busy: skip the receive step |
| link_en_i | input | 1 | Outbound path enabled |
| online_tmo_i | input | 16 | Carrier reload value when online |
| offline_tmo_i | input | 16 | Carrier reload value when offline with auto-answer |
| txrdy_i | input | 1 | USART transmitter ready |
| rxrdy_i | input | 1 | USART receiver holds a byte |
| dsr_i | input | 1 | Data Set Ready (active high) |
| perr_i | input | 1 | Parity error on the held byte |
| rx_data_i | input | 8 | Received byte from the USART |
| tx_wr_o | output | 1 | Write strobe for the USART data register |
| tx_data_o | output | 8 | Byte to transmit |
| rx_rd_o | output | 1 | Read strobe for the USART data register |
| cmd_wr_o | output | 1 | Write strobe for the USART command register |
| cmd_data_o | output | 8 | Command word |
| txq_valid_i | input | 1 | Transmit queue holds a byte |
| txq_data_i | input | 8 | Head of the transmit queue |
| txq_pop_o | output | 1 | Pop the transmit queue |
| rxq_push_o | output | 1 | Push to the receive queue |
| rxq_data_o | output | 8 | Byte for the receive queue |
| key_valid_i | input | 1 | Key byte available |
| key_data_i | input | 8 | Key byte |
| key_ack_o | output | 1 | Key byte consumed |
| key_out_valid_o | output | 1 | Forwarded key byte is valid |
| key_out_data_o | output | 8 | Forwarded key byte |
| running_o | output | 1 | A session is polling |
| done_o | output | 1 | The session has stopped |
| code_o | output | 3 | Return code: 0 continue, 1 BREAK, 2 idle, 3 carrier |

## Verification
The bench builds the block with the parameters below.

| Parameter | Bench value | Effect |
|---|---|---|
| IDLE_RELOAD | 5 | The idle expiry falls on the fifth tick after the last reload, so it is reached in a few ticks. |
| CARRIER_DEFAULT | 40 | The default carrier expiry falls on tick 296. |

The bench also drives the online and offline reload inputs with 10 and 20, which gives expiries on ticks 266 and 276. Each carrier mode, the reload caused by an accepted byte, and the BREAK-versus-idle tie can therefore be checked to the exact tick within a short run.

// File: rtl/lsup_pkg.sv
package lsup_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_TX,
        ST_RX,
        ST_KEY,
        ST_DONE
    } lsup_state_e;

    localparam logic [2:0] RC_CONTINUE = 3'd0;
    localparam logic [2:0] RC_BREAK    = 3'd1;
    localparam logic [2:0] RC_IDLE     = 3'd2;
    localparam logic [2:0] RC_CARRIER  = 3'd3;

    localparam logic [7:0] CH_HASH      = 8'h23;
    localparam logic [7:0] CH_SEND      = 8'h5F;
    localparam logic [7:0] CH_ERR_MARK  = 8'hFF;

    // Picks the carrier reload source by mode, then bumps the high byte.
    function automatic logic [15:0] carrier_load(
        input logic        online,
        input logic        autoans,
        input logic [15:0] on_val,
        input logic [15:0] off_val,
        input logic [15:0] def_val
    );
        logic [15:0] base;
        if (online)       base = on_val;
        else if (autoans) base = off_val;
        else              base = def_val;
        return {base[15:8] + 8'd1, base[7:0]};
    endfunction

endpackage

// File: rtl/lsup_txpath.sv
module lsup_txpath
    import lsup_pkg::*;
(
    input  logic       en_i,
    input  logic       link_en_i,
    input  logic       txrdy_i,
    input  logic       q_valid_i,
    input  logic [7:0] q_data_i,
    output logic       pop_o,
    output logic       wr_o,
    output logic [7:0] data_o
);

    logic fire;

    always_comb begin
        fire   = en_i && link_en_i && txrdy_i && q_valid_i;
        pop_o  = fire;
        wr_o   = fire;
        data_o = (q_data_i == CH_HASH) ? CH_SEND : q_data_i;
    end

endmodule

// File: rtl/lsup_rxpath.sv
module lsup_rxpath
    import lsup_pkg::*;
#(
    parameter logic [7:0] CMD_VALUE = 8'h15
) (
    input  logic       en_i,
    input  logic       tx_busy_i,
    input  logic       dsr_i,
    input  logic       rxrdy_i,
    input  logic       perr_i,
    input  logic [7:0] data_i,
    output logic       alive_o,
    output logic       rd_o,
    output logic       push_o,
    output logic [7:0] push_data_o,
    output logic       car_reload_o,
    output logic       cmd_wr_o,
    output logic [7:0] cmd_data_o
);

    logic active;

    always_comb begin
        active       = en_i && !tx_busy_i && dsr_i;
        alive_o      = active;
        rd_o         = active && rxrdy_i;
        push_o       = rd_o;
        car_reload_o = rd_o;
        push_data_o  = perr_i ? CH_ERR_MARK : data_i;
        cmd_wr_o     = rd_o && perr_i;
        cmd_data_o   = CMD_VALUE;
    end

endmodule

// File: rtl/lsup_timers.sv
module lsup_timers #(
    parameter int IDLE_RELOAD = 100,
    parameter int CAR_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle_load_i,
    input  logic             car_load_i,
    input  logic [CAR_W-1:0] car_val_i,
    input  logic             dec_i,
    output logic             idle_exp_o,
    output logic             car_exp_o
);

    localparam int IDLE_W = $clog2(IDLE_RELOAD + 1);

    logic [IDLE_W-1:0] idle_cnt;
    logic [CAR_W-1:0]  car_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_cnt <= '0;
        end else if (idle_load_i) begin
            idle_cnt <= IDLE_W'(IDLE_RELOAD);
        end else if (dec_i && idle_cnt != '0) begin
            idle_cnt <= idle_cnt - IDLE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            car_cnt <= '0;
        end else if (car_load_i) begin
            car_cnt <= car_val_i;
        end else if (dec_i && car_cnt != '0) begin
            car_cnt <= car_cnt - CAR_W'(1);
        end
    end

    // Expiry flags mark the tick that takes a counter from one to zero.
    assign idle_exp_o = dec_i && (idle_cnt == IDLE_W'(1));
    assign car_exp_o  = dec_i && (car_cnt == CAR_W'(1));

endmodule

// File: rtl/modem_link_supervisor.sv
module modem_link_supervisor
    import lsup_pkg::*;
#(
    parameter int          IDLE_RELOAD     = 100,
    parameter logic [15:0] CARRIER_DEFAULT = 16'd25000,
    parameter logic [7:0]  CMD_VALUE       = 8'h15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go_i,
    input  logic        break_i,
    input  logic        scan_tick_i,
    input  logic        online_i,
    input  logic        autoans_i,
    input  logic        kblock_i,
    input  logic        tx_busy_i,
    input  logic        link_en_i,
    input  logic [15:0] online_tmo_i,
    input  logic [15:0] offline_tmo_i,
    input  logic        txrdy_i,
    input  logic        rxrdy_i,
    input  logic        dsr_i,
    input  logic        perr_i,
    input  logic [7:0]  rx_data_i,
    output logic        tx_wr_o,
    output logic [7:0]  tx_data_o,
    output logic        rx_rd_o,
    output logic        cmd_wr_o,
    output logic [7:0]  cmd_data_o,
    input  logic        txq_valid_i,
    input  logic [7:0]  txq_data_i,
    output logic        txq_pop_o,
    output logic        rxq_push_o,
    output logic [7:0]  rxq_data_o,
    input  logic        key_valid_i,
    input  logic [7:0]  key_data_i,
    output logic        key_ack_o,
    output logic        key_out_valid_o,
    output logic [7:0]  key_out_data_o,
    output logic        running_o,
    output logic        done_o,
    output logic [2:0]  code_o
);

    localparam int CAR_W = 16;

    lsup_state_e state;
    logic [2:0]  code_r;
    logic        tick_pend;

    logic        tx_en;
    logic        rx_en;
    logic        go_accept;
    logic [2:0]  key_code;
    logic        alive;
    logic        car_reload;
    logic        idle_exp;
    logic        car_exp;
    logic        dec;
    logic [CAR_W-1:0] car_val;

    // State register, return code and tick latch.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            code_r    <= RC_CONTINUE;
            tick_pend <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE, ST_DONE: begin
                    tick_pend <= 1'b0;
                    if (go_i) begin
                        state  <= ST_CLEAR;
                        code_r <= RC_CONTINUE;
                    end
                end
                ST_CLEAR: begin
                    code_r    <= RC_CONTINUE;
                    tick_pend <= tick_pend || scan_tick_i;
                    state     <= ST_TX;
                end
                ST_TX: begin
                    tick_pend <= tick_pend || scan_tick_i;
                    state     <= ST_RX;
                end
                ST_RX: begin
                    tick_pend <= tick_pend || scan_tick_i;
                    state     <= ST_KEY;
                end
                ST_KEY: begin
                    tick_pend <= scan_tick_i;
                    code_r    <= key_code;
                    state     <= (key_code != RC_CONTINUE) ? ST_DONE : ST_CLEAR;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Step enables, keyboard step and return-code selection.
    always_comb begin
        tx_en           = 1'b0;
        rx_en           = 1'b0;
        dec             = 1'b0;
        key_code        = RC_CONTINUE;
        key_ack_o       = 1'b0;
        key_out_valid_o = 1'b0;
        key_out_data_o  = key_data_i;
        go_accept       = 1'b0;
        unique case (state)
            ST_IDLE, ST_DONE: begin
                go_accept = go_i;
            end
            ST_CLEAR: begin
            end
            ST_TX: begin
                tx_en = 1'b1;
            end
            ST_RX: begin
                rx_en = 1'b1;
            end
            ST_KEY: begin
                dec = tick_pend;
                if (break_i) begin
                    key_code = RC_BREAK;
                end else begin
                    if (idle_exp)     key_code = RC_IDLE;
                    else if (car_exp) key_code = RC_CARRIER;
                    key_ack_o       = key_valid_i;
                    key_out_valid_o = key_valid_i && !kblock_i;
                end
            end
            default: begin
            end
        endcase
    end

    assign car_val   = carrier_load(online_i, autoans_i, online_tmo_i,
                                    offline_tmo_i, CARRIER_DEFAULT);
    assign running_o = (state == ST_CLEAR) || (state == ST_TX) ||
                       (state == ST_RX) || (state == ST_KEY);
    assign done_o    = (state == ST_DONE);
    assign code_o    = code_r;

    lsup_txpath u_tx (
        .en_i      (tx_en),
        .link_en_i (link_en_i),
        .txrdy_i   (txrdy_i),
        .q_valid_i (txq_valid_i),
        .q_data_i  (txq_data_i),
        .pop_o     (txq_pop_o),
        .wr_o      (tx_wr_o),
        .data_o    (tx_data_o)
    );

    lsup_rxpath #(.CMD_VALUE(CMD_VALUE)) u_rx (
        .en_i         (rx_en),
        .tx_busy_i    (tx_busy_i),
        .dsr_i        (dsr_i),
        .rxrdy_i      (rxrdy_i),
        .perr_i       (perr_i),
        .data_i       (rx_data_i),
        .alive_o      (alive),
        .rd_o         (rx_rd_o),
        .push_o       (rxq_push_o),
        .push_data_o  (rxq_data_o),
        .car_reload_o (car_reload),
        .cmd_wr_o     (cmd_wr_o),
        .cmd_data_o   (cmd_data_o)
    );

    lsup_timers #(.IDLE_RELOAD(IDLE_RELOAD), .CAR_W(CAR_W)) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .idle_load_i (go_accept || alive),
        .car_load_i  (go_accept || car_reload),
        .car_val_i   (car_val),
        .dec_i       (dec),
        .idle_exp_o  (idle_exp),
        .car_exp_o   (car_exp)
    );

endmodule

// File: rtl/lsup_checker.sv
module lsup_checker #(
    parameter logic [7:0] CMD_VALUE = 8'h15
) (
    input logic       clk,
    input logic       rst_n,
    input logic       go_i,
    input logic       link_en_i,
    input logic       txrdy_i,
    input logic       txq_valid_i,
    input logic [7:0] txq_data_i,
    input logic       tx_wr_o,
    input logic [7:0] tx_data_o,
    input logic       dsr_i,
    input logic       tx_busy_i,
    input logic       perr_i,
    input logic       rx_rd_o,
    input logic       rxq_push_o,
    input logic [7:0] rxq_data_o,
    input logic       cmd_wr_o,
    input logic [7:0] cmd_data_o,
    input logic       kblock_i,
    input logic       key_out_valid_o,
    input logic       running_o,
    input logic       done_o,
    input logic [2:0] code_o
);

    p_tx_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr_o |-> (link_en_i && txrdy_i && txq_valid_i));

    p_hash_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr_o && txq_data_i == 8'h23) |-> (tx_data_o == 8'h5F));

    p_rx_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rd_o |-> (dsr_i && !tx_busy_i));

    p_perr_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd_o && perr_i) |-> (cmd_wr_o && cmd_data_o == CMD_VALUE &&
                                 rxq_data_o == 8'hFF));

    p_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rd_o |-> rxq_push_o);

    p_run_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
        running_o |-> (code_o == 3'd0));

    p_hold_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !go_i) |=> (done_o && $stable(code_o)));

    p_lock_r13: assert property (@(posedge clk) disable iff (!rst_n)
        kblock_i |-> !key_out_valid_o);

    p_state_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({running_o, done_o}));

endmodule

bind modem_link_supervisor lsup_checker #(.CMD_VALUE(CMD_VALUE)) u_lsup_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .go_i            (go_i),
    .link_en_i       (link_en_i),
    .txrdy_i         (txrdy_i),
    .txq_valid_i     (txq_valid_i),
    .txq_data_i      (txq_data_i),
    .tx_wr_o         (tx_wr_o),
    .tx_data_o       (tx_data_o),
    .dsr_i           (dsr_i),
    .tx_busy_i       (tx_busy_i),
    .perr_i          (perr_i),
    .rx_rd_o         (rx_rd_o),
    .rxq_push_o      (rxq_push_o),
    .rxq_data_o      (rxq_data_o),
    .cmd_wr_o        (cmd_wr_o),
    .cmd_data_o      (cmd_data_o),
    .kblock_i        (kblock_i),
    .key_out_valid_o (key_out_valid_o),
    .running_o       (running_o),
    .done_o          (done_o),
    .code_o          (code_o)
);

// File: tb/test_modem_link_supervisor.sv
module test_modem_link_supervisor;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go_i = 0, break_i = 0, scan_tick_i = 0, online_i = 0, autoans_i = 0;
    logic kblock_i = 0, tx_busy_i = 0, link_en_i = 0;
    logic [15:0] online_tmo_i = 16'd10, offline_tmo_i = 16'd20;
    logic txrdy_i = 0, rxrdy_i = 0, dsr_i = 0, perr_i = 0;
    logic [7:0] rx_data_i = 0;
    logic tx_wr_o, rx_rd_o, cmd_wr_o, txq_pop_o, rxq_push_o;
    logic [7:0] tx_data_o, cmd_data_o, rxq_data_o, key_out_data_o;
    logic txq_valid_i = 0;
    logic [7:0] txq_data_i = 0;
    logic key_valid_i = 0;
    logic [7:0] key_data_i = 0;
    logic key_ack_o, key_out_valid_o, running_o, done_o;
    logic [2:0] code_o;

    int n_tests = 0;
    int n_fail = 0;
    int n_tx = 0, n_rd = 0, n_cmd = 0, n_key = 0, n_ack = 0;
    bit finished = 0;
    logic [7:0] exp_tx[$];
    logic [7:0] exp_rx[$];
    logic [7:0] exp_key[$];

    always #5 clk = ~clk;

    modem_link_supervisor #(
        .IDLE_RELOAD(5),
        .CARRIER_DEFAULT(16'd40),
        .CMD_VALUE(8'h15)
    ) i_modem_link_supervisor (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Scoreboard monitors, sampling on the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_wr_o) begin
                n_tx++;
                if (exp_tx.size() == 0) chk(0, "R1 unexpected tx write", tx_data_o, 0);
                else begin
                    logic [7:0] e;
                    e = exp_tx.pop_front();
                    chk(tx_data_o == e, "R2 tx byte", tx_data_o, e);
                end
            end
            if (rx_rd_o) n_rd++;
            if (rxq_push_o) begin
                if (exp_rx.size() == 0) chk(0, "R6 unexpected rx push", rxq_data_o, 0);
                else begin
                    logic [7:0] e;
                    e = exp_rx.pop_front();
                    chk(rxq_data_o == e, "R5 rx queued byte", rxq_data_o, e);
                end
            end
            if (cmd_wr_o) begin
                n_cmd++;
                chk(cmd_data_o == 8'h15, "R5 command rewrite", cmd_data_o, 8'h15);
            end
            if (key_ack_o) n_ack++;
            if (key_out_valid_o) begin
                n_key++;
                if (exp_key.size() == 0) chk(0, "R13 unexpected key", key_out_data_o, 0);
                else begin
                    logic [7:0] e;
                    e = exp_key.pop_front();
                    chk(key_out_data_o == e, "R13 key byte", key_out_data_o, e);
                end
            end
        end
    end

    task automatic start_session();
        go_i = 1; cyc(1); go_i = 0; cyc(1);
    endtask

    task automatic tick();
        scan_tick_i = 1; cyc(1); scan_tick_i = 0; cyc(7);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic send_tx(input logic [7:0] d, input logic [7:0] e);
        exp_tx.push_back(e);
        txq_data_i = d; txq_valid_i = 1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (txq_pop_o) break;
        end
        @(posedge clk); #1;
        txq_valid_i = 0;
    endtask

    task automatic recv(input logic [7:0] d, input logic pe, input logic [7:0] e);
        exp_rx.push_back(e);
        rx_data_i = d; perr_i = pe; rxrdy_i = 1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (rx_rd_o) break;
        end
        @(posedge clk); #1;
        rxrdy_i = 0; perr_i = 0;
    endtask

    task automatic send_key(input logic [7:0] d);
        key_data_i = d; key_valid_i = 1;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (key_ack_o) break;
        end
        @(posedge clk); #1;
        key_valid_i = 0;
    endtask

    task automatic carrier_run(input int total, input string tag);
        ticks(total - 1);
        chk(running_o === 1'b1, {tag, " running before last tick"}, running_o, 1);
        tick();
        chk(done_o === 1'b1 && code_o == 3'd3, {tag, " carrier code"}, code_o, 3);
    endtask

    initial begin
        int snap;
        cyc(5);
        rst_n = 1;
        cyc(2);
        chk(code_o == 3'd0, "R12 reset code", code_o, 0);
        chk(!running_o && !done_o, "R12 reset state", {running_o, done_o}, 0);

        link_en_i = 1; txrdy_i = 1; dsr_i = 1;
        start_session();
        chk(running_o === 1'b1 && code_o == 3'd0, "R12 session start", code_o, 0);

        // Outbound bytes and substitution.
        send_tx(8'h41, 8'h41);
        send_tx(8'h23, 8'h5F);
        send_tx(8'h5F, 8'h5F);
        cyc(4);
        chk(exp_tx.size() == 0, "R1 all tx bytes sent", exp_tx.size(), 0);

        // Outbound gating.
        snap = n_tx;
        link_en_i = 0; txq_data_i = 8'h30; txq_valid_i = 1; cyc(20);
        chk(n_tx == snap, "R1 no tx when link disabled", n_tx - snap, 0);
        link_en_i = 1; txrdy_i = 0; cyc(20);
        chk(n_tx == snap, "R1 no tx when not ready", n_tx - snap, 0);
        txq_valid_i = 0; txrdy_i = 1;

        // Inbound bytes.
        snap = n_cmd;
        recv(8'h55, 0, 8'h55);
        cyc(2);
        chk(n_cmd == snap, "R5 no rewrite on clean byte", n_cmd - snap, 0);
        recv(8'h33, 1, 8'hFF);
        cyc(2);
        chk(n_cmd == snap + 1, "R5 rewrite on parity error", n_cmd - snap, 1);
        chk(exp_rx.size() == 0, "R6 rx bytes queued", exp_rx.size(), 0);

        // Inbound gating.
        snap = n_rd;
        dsr_i = 0; rx_data_i = 8'h11; rxrdy_i = 1; cyc(20);
        chk(n_rd == snap, "R3 no read without DSR", n_rd - snap, 0);
        dsr_i = 1; tx_busy_i = 1; cyc(20);
        chk(n_rd == snap, "R3 no read while tx busy", n_rd - snap, 0);
        rxrdy_i = 0; tx_busy_i = 0;

        // Keyboard lock.
        exp_key.push_back(8'h61);
        send_key(8'h61);
        cyc(2);
        chk(n_key == 1, "R13 unlocked key forwarded", n_key, 1);
        kblock_i = 1; snap = n_ack;
        send_key(8'h62);
        cyc(2);
        chk(n_key == 1 && n_ack == snap + 1, "R13 locked key discarded", n_key, 1);
        kblock_i = 0;

        // Idle reload and expiry.
        ticks(20);
        chk(running_o === 1'b1, "R4 idle reloads while DSR high", running_o, 1);
        dsr_i = 0;
        ticks(4);
        chk(running_o === 1'b1, "R8 idle not expired after 4 ticks", running_o, 1);
        tick();
        chk(done_o === 1'b1 && code_o == 3'd2, "R8 idle expiry code", code_o, 2);
        ticks(2);
        chk(code_o == 3'd2, "R12 code held when stopped", code_o, 2);

        // Online carrier with reload by an accepted byte.
        dsr_i = 1; online_i = 1;
        start_session();
        chk(running_o === 1'b1 && code_o == 3'd0, "R12 restart clears code", code_o, 0);
        ticks(200);
        recv(8'h4A, 0, 8'h4A);
        carrier_run(266, "R6 R7 R9 online");

        online_i = 0; autoans_i = 1;
        start_session();
        carrier_run(276, "R7 R9 offline auto-answer");

        autoans_i = 0;
        start_session();
        carrier_run(296, "R7 R9 default");

        // BREAK.
        start_session();
        cyc(4);
        break_i = 1; cyc(8);
        chk(done_o === 1'b1 && code_o == 3'd1, "R10 break code", code_o, 1);
        break_i = 0;

        // BREAK and idle expiry in the same keyboard step.
        start_session();
        dsr_i = 0;
        ticks(4);
        scan_tick_i = 1; cyc(1);
        scan_tick_i = 0; break_i = 1; cyc(8);
        chk(done_o === 1'b1 && code_o == 3'd1, "R11 break beats idle", code_o, 1);
        break_i = 0;

        chk(exp_tx.size() == 0 && exp_rx.size() == 0 && exp_key.size() == 0,
            "R6 scoreboard drained", exp_tx.size() + exp_rx.size(), 0);

        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule